// File: doc/BRIEF.md
# Serial Register-Access Slave with Pause Control

This block is the serial front end for a small bank of control registers. It has four 8-bit wiper registers. Each wiper has four 8-bit data registers beside it, held in ordinary flops. A host selects the block with an active-low select line and then shifts three bytes in, most significant bit first. The first byte is an identifier whose address bits must equal the two strap inputs. The second byte is an instruction. The third byte carries write data from the host, or read data back to the host. The block can read or write a wiper, read or write a data register, or copy a data register into its wiper. The current wiper positions are always visible on a flat output bus.

All serial inputs are sampled by the block clock, which must run several times faster than the serial clock. The block finds the serial clock edges by comparing each sample with the one before. A pause input freezes the transfer in the middle of a byte without losing its position. A write-protect input guards the data registers. A lockout after reset keeps the block deaf until it has seen the select line fall.

Top module: `serreg_slave`

## Requirements
- R1: `sdi` is sampled on rising `sck` edges, most significant bit first. A frame is an identifier byte, then an instruction byte `{op[3:0], reg[1:0], pot[1:0]}`, then a data byte. The write-wiper opcode 4'hA loads the data byte into wiper `pot` on the 24th rising edge.
- R2: Read-wiper (4'h9) and read-data-register (4'hB) put the selected value on `sdo`, most significant bit first. Each bit is updated on a falling `sck` edge, starting with the falling edge after the 16th rising edge. `sdo_oe` is high only during the data byte of a matched read.
- R3: While `cs_n` is high, `sdo_oe` is low. Raising `cs_n` abandons a partial frame, and no write takes effect from it.
- R4: Bringing `hold_n` low while `sck` is low pauses the transfer. While paused, `sck` edges are ignored, the bit position is kept and `sdo_oe` is low. Bringing `hold_n` high while `sck` is low resumes the transfer at the kept bit.
- R5: The identifier byte must be 4'b0101, then `strap[1]`, `strap[0]`, then 2'b00. On a mismatch the rest of the frame is ignored and `sdo_oe` stays low until `cs_n` rises.
- R6: After reset, no frame is accepted until a high-to-low transition of `cs_n` has been seen.
- R7: While `wp_n` is low, the write-data-register opcode (4'hC) leaves the data register `reg` of `pot` unchanged. Wiper writes still take effect.
- R8: The copy opcode 4'hD loads data register `reg` of `pot` into wiper `pot` at the end of the instruction byte, whatever the level of `wp_n`.
- R9: The four wipers are independent. A write or copy changes only the selected wiper.
- R10: After reset, all wipers and data registers read 0 and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to oversample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| strap | input | 2 | Address straps matched against the identifier byte |
| wp_n | input | 1 | Active-low write protect for the data registers |
| sdo | output | 1 | Serial data out, meaningful while `sdo_oe` is high |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high-impedance |
| wiper_pos | output | NPOT*8 | Wiper values, wiper n in bits [8n+7:8n] |

## Verification
The assertions assume that the serial pins are already synchronous to `clk`. They also assume that each `sck` level lasts at least two clocks, and that `hold_n` and `cs_n` only change while `sck` is low. The bench host keeps to this. It changes every pin at a falling clock edge, holds each `sck` phase for two or more clocks, and makes its pause and resume changes only with `sck` parked low. While paused, the bench toggles `sck` with junk data to show that those edges are dropped.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;
  localparam logic [3:0] ID_HI = 4'b0101;
  localparam logic [1:0] ID_LO = 2'b00;

  typedef enum logic [3:0] {
    OP_RD_WIPER = 4'h9,
    OP_WR_WIPER = 4'hA,
    OP_RD_DATA  = 4'hB,
    OP_WR_DATA  = 4'hC,
    OP_COPY     = 4'hD
  } op_e;

  typedef enum logic [1:0] {
    PH_ID, PH_INSTR, PH_DATA, PH_DONE
  } phase_e;
endpackage

// File: rtl/serreg_ctl.sv
module serreg_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic armed,
  output logic paused,
  output logic active,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_q, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b0;
      armed  <= 1'b0;
      paused <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_q && !cs_n) armed <= 1'b1;
      if (cs_n)      paused <= 1'b0;
      else if (!sck) paused <= !hold_n;
    end
  end

  assign active   = !cs_n && armed;
  assign sck_rise = active && !paused && sck && !sck_q;
  assign sck_fall = active && !paused && !sck && sck_q;
endmodule

// File: rtl/serreg_frame.sv
module serreg_frame
  import serreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic [1:0]        strap,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              active,
  input  logic              paused,
  input  logic [DATA_W-1:0] rd_val,
  output phase_e            phase,
  output logic [2:0]        bit_cnt,
  output logic              id_ok,
  output logic [SEL_W-1:0]  sel_pot,
  output logic [SEL_W-1:0]  sel_reg,
  output logic              rd_is_data,
  output logic              wr_wiper,
  output logic              wr_data,
  output logic              do_copy,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [6:0]        rx;
  logic [7:0]        instr;
  logic [DATA_W-1:0] tx;
  logic              tx_live;
  logic              last, id_match, is_read;
  logic [3:0]        op;

  assign rx_byte  = {rx, sdi};
  assign last     = sck_rise && (bit_cnt == 3'd7);
  assign id_match = (rx_byte[7:4] == ID_HI) && (rx_byte[3:2] == strap) &&
                    (rx_byte[1:0] == ID_LO);
  assign op       = instr[7:4];
  assign is_read  = (op == OP_RD_WIPER) || (op == OP_RD_DATA);
  assign rd_is_data = (op == OP_RD_DATA);

  // copy is decided from the byte still arriving; writes use the held instruction
  assign sel_pot  = (phase == PH_INSTR) ? rx_byte[1:0] : instr[1:0];
  assign sel_reg  = (phase == PH_INSTR) ? rx_byte[3:2] : instr[3:2];
  assign do_copy  = last && (phase == PH_INSTR) && (rx_byte[7:4] == OP_COPY);
  assign wr_wiper = last && (phase == PH_DATA) && (op == OP_WR_WIPER);
  assign wr_data  = last && (phase == PH_DATA) && (op == OP_WR_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      bit_cnt <= 3'd0;
      phase   <= PH_ID;
      rx      <= '0;
      id_ok   <= 1'b0;
      instr   <= '0;
      tx      <= '0;
      tx_live <= 1'b0;
    end else begin
      if (sck_rise && phase != PH_DONE) begin
        rx      <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_ID: begin
              id_ok <= id_match;
              phase <= id_match ? PH_INSTR : PH_DONE;
            end
            PH_INSTR: begin
              instr <= rx_byte;
              phase <= PH_DATA;
            end
            default: phase <= PH_DONE;
          endcase
        end
      end
      if (sck_fall && phase == PH_DATA && is_read) begin
        if (!tx_live) begin
          tx      <= rd_val;
          tx_live <= 1'b1;
        end else begin
          tx <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo    = tx[DATA_W-1];
  assign sdo_oe = active && !paused && (phase == PH_DATA) && tx_live;
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
  import serreg_pkg::*;
#(
  parameter int NPOT = 4,
  parameter int NREG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp_n,
  input  logic                   wr_wiper,
  input  logic                   wr_data,
  input  logic                   do_copy,
  input  logic                   rd_is_data,
  input  logic [SEL_W-1:0]       sel_pot,
  input  logic [SEL_W-1:0]       sel_reg,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rd_val,
  output logic [NPOT*DATA_W-1:0] wiper_pos
);
  logic [DATA_W-1:0] wiper_r [NPOT];
  logic [DATA_W-1:0] data_r  [NPOT][NREG];

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic hit;
    assign hit = (sel_pot == SEL_W'(p));

    always_ff @(posedge clk) begin
      if (!rst_n)               wiper_r[p] <= '0;
      else if (wr_wiper && hit) wiper_r[p] <= wdata;
      else if (do_copy && hit)  wiper_r[p] <= data_r[p][sel_reg];
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          data_r[p][r] <= '0;
        else if (wr_data && wp_n && hit && sel_reg == SEL_W'(r))
          data_r[p][r] <= wdata;
      end
    end

    assign wiper_pos[p*DATA_W +: DATA_W] = wiper_r[p];
  end

  assign rd_val = rd_is_data ? data_r[sel_pot][sel_reg] : wiper_r[sel_pot];
endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
  import serreg_pkg::*;
#(
  parameter int NPOT = 4,
  parameter int NREG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sck,
  input  logic                   sdi,
  input  logic                   hold_n,
  input  logic [1:0]             strap,
  input  logic                   wp_n,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [NPOT*DATA_W-1:0] wiper_pos
);
  logic armed, paused, active, sck_rise, sck_fall;
  logic id_ok, rd_is_data, wr_wiper, wr_data, do_copy;
  logic [2:0] bit_cnt;
  logic [SEL_W-1:0] sel_pot, sel_reg;
  logic [DATA_W-1:0] rx_byte, rd_val;
  phase_e phase;

  serreg_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .armed(armed), .paused(paused), .active(active),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  serreg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .strap(strap),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .active(active), .paused(paused),
    .rd_val(rd_val), .phase(phase), .bit_cnt(bit_cnt), .id_ok(id_ok),
    .sel_pot(sel_pot), .sel_reg(sel_reg), .rd_is_data(rd_is_data),
    .wr_wiper(wr_wiper), .wr_data(wr_data), .do_copy(do_copy),
    .rx_byte(rx_byte), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  serreg_bank #(.NPOT(NPOT), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wr_wiper(wr_wiper),
    .wr_data(wr_data), .do_copy(do_copy), .rd_is_data(rd_is_data),
    .sel_pot(sel_pot), .sel_reg(sel_reg), .wdata(rx_byte),
    .rd_val(rd_val), .wiper_pos(wiper_pos)
  );
endmodule

// File: rtl/serreg_slave_chk.sv
module serreg_slave_chk
  import serreg_pkg::*;
#(
  parameter int NPOT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   sdo,
  input logic                   sdo_oe,
  input logic [NPOT*DATA_W-1:0] wiper_pos,
  input logic                   armed,
  input logic                   paused,
  input logic                   sck_rise,
  input logic                   sck_fall,
  input phase_e                 phase,
  input logic [2:0]             bit_cnt,
  input logic                   id_ok
);
  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  // R4
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !sdo_oe);

  // R4
  pause_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_n) |=> (cs_n || ($stable(bit_cnt) && $stable(phase))));

  // R5
  id_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_ID && !id_ok) |-> !sdo_oe);

  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(wiper_pos));

  // R1
  wiper_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_pos) |-> $past(sck_rise));

  // R2
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> ($past(sck_fall) || $past(paused)));

  // R2
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> $past(sck_fall));
endmodule

bind serreg_slave serreg_slave_chk #(.NPOT(NPOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .wiper_pos(wiper_pos), .armed(armed), .paused(paused),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .phase(phase),
  .bit_cnt(bit_cnt), .id_ok(id_ok)
);

// File: tb/serreg_slave_bench.sv
module serreg_slave_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic wp_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sdo, sdo_oe;
  logic [31:0] wiper_pos;

  serreg_slave u_serreg_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .hold_n(hold_n), .strap(strap), .wp_n(wp_n), .sdo(sdo),
    .sdo_oe(sdo_oe), .wiper_pos(wiper_pos)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit m_armed = 1'b0;
  int mw[4];
  int md[4][4];
  int pk = 0, pp = 0, pr = 0, pv = 0;

  localparam logic [7:0] ID_GOOD = 8'h58;
  localparam logic [7:0] ID_BAD  = 8'h54;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of all wipers against the model (R9)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done)
      for (int p = 0; p < 4; p++)
        check(int'(wiper_pos[p*8 +: 8]) == mw[p], "R9 wiper", int'(wiper_pos[p*8 +: 8]), mw[p]);
  end

  task automatic bit_out(input logic b, output logic rb, output logic oe);
    @(negedge clk);
    sdi = b; rb = sdo; oe = sdo_oe; sck = 1'b1;
    if (pk == 1) mw[pp] = pv;
    if (pk == 2) md[pp][pr] = pv;
    pk = 0;
    @(negedge clk); @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic pause_run();
    @(negedge clk); hold_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(sdo_oe == 1'b0, "R4 paused oe", int'(sdo_oe), 0);
    for (int k = 0; k < 3; k++) begin
      sdi = k[0]; sck = 1'b1;
      @(negedge clk); @(negedge clk);
      sck = 1'b0;
      @(negedge clk); @(negedge clk);
    end
    hold_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] idb, input logic [7:0] ins, input logic [7:0] dat,
                     input int nbits, input int hold_at, input string req);
    logic [23:0] frame;
    logic [7:0] rx;
    logic rb, oe;
    bit match, rd, oe_bad;
    int op, pot, rg, exp_rd;
    frame = {idb, ins, dat};
    rx = '0; oe_bad = 1'b0;
    @(negedge clk);
    if (cs_n) m_armed = 1'b1;
    cs_n = 1'b0;
    @(negedge clk);
    match = m_armed && (idb == ID_GOOD);
    op = int'(ins[7:4]); rg = int'(ins[3:2]); pot = int'(ins[1:0]);
    rd = match && (op == 9 || op == 11) && nbits == 24;
    exp_rd = (op == 11) ? md[pot][rg] : mw[pot];
    for (int i = 0; i < nbits; i++) begin
      if (i == hold_at) pause_run();
      if (match && i == 15 && op == 13) begin pk = 1; pp = pot; pv = md[pot][rg]; end
      if (match && i == 23 && op == 10) begin pk = 1; pp = pot; pv = int'(dat); end
      if (match && i == 23 && op == 12 && wp_n) begin pk = 2; pp = pot; pr = rg; pv = int'(dat); end
      bit_out(frame[23-i], rb, oe);
      if (i >= 16) rx[23-i] = rb;
      if (oe != (rd && i >= 16)) oe_bad = 1'b1;
    end
    check(!oe_bad, {req, " oe window"}, int'(oe_bad), 0);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(sdo_oe == 1'b0, "R3 oe after deselect", int'(sdo_oe), 0);
    if (rd) check(int'(rx) == exp_rd, {req, " read data"}, int'(rx), exp_rd);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      mw[p] = 0;
      for (int r = 0; r < 4; r++) md[p][r] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(wiper_pos == 32'h0, "R10 wipers", int'(wiper_pos), 0);
    check(sdo_oe == 1'b0, "R10 oe", int'(sdo_oe), 0);

    // R6: cs_n was low through reset, so this frame must be ignored
    txn(ID_GOOD, 8'hA0, 8'h5A, 24, -1, "R6");
    check(wiper_pos[7:0] == 8'h00, "R6 lockout", int'(wiper_pos[7:0]), 0);

    // R1 and R9: write each wiper
    txn(ID_GOOD, 8'hA1, 8'hA5, 24, -1, "R1");
    check(wiper_pos[15:8] == 8'hA5, "R1 wiper1", int'(wiper_pos[15:8]), 'hA5);
    txn(ID_GOOD, 8'hA2, 8'h81, 24, -1, "R9");
    txn(ID_GOOD, 8'hA3, 8'h7E, 24, -1, "R9");
    txn(ID_GOOD, 8'hA0, 8'h01, 24, -1, "R9");

    // R2: reads of wipers
    txn(ID_GOOD, 8'h91, 8'h00, 24, -1, "R2");
    txn(ID_GOOD, 8'h93, 8'hFF, 24, -1, "R2");

    // R7: data register writes and protection
    txn(ID_GOOD, 8'hCE, 8'h3C, 24, -1, "R7");
    txn(ID_GOOD, 8'hBE, 8'h00, 24, -1, "R7");
    wp_n = 1'b0;
    txn(ID_GOOD, 8'hCE, 8'hFF, 24, -1, "R7");
    txn(ID_GOOD, 8'hBE, 8'h00, 24, -1, "R7");
    txn(ID_GOOD, 8'hA2, 8'h44, 24, -1, "R7");
    check(wiper_pos[23:16] == 8'h44, "R7 wiper under wp", int'(wiper_pos[23:16]), 'h44);

    // R8: copy with protection active
    txn(ID_GOOD, 8'hDE, 8'h00, 16, -1, "R8");
    check(wiper_pos[23:16] == 8'h3C, "R8 copy", int'(wiper_pos[23:16]), 'h3C);
    wp_n = 1'b1;

    // R5: wrong strap address
    txn(ID_BAD, 8'hA0, 8'hEE, 24, -1, "R5");
    check(wiper_pos[7:0] == 8'h01, "R5 ignored", int'(wiper_pos[7:0]), 1);
    txn(ID_BAD, 8'h91, 8'h00, 24, -1, "R5");

    // R3: abandoned frame
    txn(ID_GOOD, 8'hA0, 8'hC3, 20, -1, "R3");
    check(wiper_pos[7:0] == 8'h01, "R3 abort", int'(wiper_pos[7:0]), 1);
    txn(ID_GOOD, 8'h90, 8'h00, 24, -1, "R3");

    // R4: pause in the id byte, the data byte and during a read
    txn(ID_GOOD, 8'hA3, 8'h96, 24, 5, "R4");
    txn(ID_GOOD, 8'hA1, 8'h2D, 24, 19, "R4");
    check(wiper_pos[15:8] == 8'h2D, "R4 resumed write", int'(wiper_pos[15:8]), 'h2D);
    txn(ID_GOOD, 8'h93, 8'h00, 24, 20, "R4");
    txn(ID_GOOD, 8'hCD, 8'hB7, 24, 10, "R4");
    txn(ID_GOOD, 8'hB7, 8'h00, 24, 18, "R4");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule